// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Controller

This block keeps the tags and the per-block state of a parameterised cache. It does not store any data. Three exponent parameters set the geometry: `C` gives the total capacity of 2^C bytes, `B` gives the block size of 2^B bytes, and `S` gives 2^S ways per set. With `S = 0` the cache is direct-mapped. With `S = C - B` it is one fully associative set. Requests are single bytes, so no request can span two blocks.

A requester offers a read or a write on a valid/ready port. In the cycle the request is accepted, the controller signals hit or miss. A hit completes in that cycle. On a miss the controller stays busy:
- If the chosen victim is valid and dirty, it first writes that block back to the next memory level.
- It then requests a fill for the missing block.
- It installs the new tag and lowers nothing further; `req_ready` rises again when the fill is done.

Replacement picks the least recently used way. The write policy is write-back with write-allocate. Running statistics counters track reads, writes, hits and misses of each type, and write-backs.

Top module: `cache_ctrl`

## Requirements
- R1: The address splits into a byte offset (bits [B-1:0]), a set index (the next C-B-S bits) and a tag (all remaining upper bits). Two bytes that differ only in their offset bits belong to the same block.
- R2: The hit/miss result is valid in the cycle a request is accepted. In that cycle `rsp_valid` is high and `rsp_hit` is 1 for a hit and 0 for a miss. After a hit, `req_ready` stays high and no memory request is made.
- R3: After reset, every block is invalid and all counters read zero. The first access to any block is therefore a miss.
- R4: When all ways of a set are valid, a miss replaces the least recently used way. Both read hits and write hits make the accessed block the most recently used.
- R5: On a miss, an invalid way is chosen before any valid way. Among the invalid ways, the lowest-numbered one is chosen.
- R6: Writes allocate. A write miss issues a fill request for the block-aligned address (offset bits 0). The installed block is then dirty. A read miss installs a clean block.
- R7: Write-back works as follows:
  - A write hit marks the block dirty.
  - Evicting a valid dirty block issues exactly one write-back request. Its address is the victim's block-aligned address: the victim tag, the same set index and offset 0.
  - Evicting a clean block issues no write-back.
- R8: After a miss, `req_ready` stays low until any write-back and then the fill have completed. A write-back always comes before the fill. Each memory request holds its valid and address until its ready is sampled high.
- R9: The counters `cnt_rd`, `cnt_wr`, `cnt_rd_hit`, `cnt_rd_miss`, `cnt_wr_hit` and `cnt_wr_miss` each increment once per accepted request of the matching kind. `cnt_wb` increments once per completed write-back.
- R10: `cnt_hit` equals read hits plus write hits, and `cnt_miss` equals read misses plus write misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_ready | output | 1 | Controller idle, can accept a request |
| rsp_valid | output | 1 | Request accepted this cycle |
| rsp_hit | output | 1 | Hit (1) or miss (0) of the accepted request |
| wb_valid | output | 1 | Write-back request to next level |
| wb_addr | output | ADDR_W | Block-aligned write-back address |
| wb_ready | input | 1 | Next level takes the write-back |
| fill_valid | output | 1 | Fill request to next level |
| fill_addr | output | ADDR_W | Block-aligned fill address |
| fill_ready | input | 1 | Fill completed by next level |
| cnt_rd | output | CNT_W | Reads accepted |
| cnt_wr | output | CNT_W | Writes accepted |
| cnt_rd_hit | output | CNT_W | Read hits |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_wr_hit | output | CNT_W | Write hits |
| cnt_wr_miss | output | CNT_W | Write misses |
| cnt_wb | output | CNT_W | Completed write-backs |
| cnt_hit | output | CNT_W | Total hits |
| cnt_miss | output | CNT_W | Total misses |

## Verification
The properties assume the following about the next memory level:
- It raises `wb_ready` only while `wb_valid` is high, and `fill_ready` only while `fill_valid` is high.
- A ready may be withheld for any number of cycles.

The properties also assume that requests are offered only while `req_ready` is high, and that `req_*` settles before the edge that samples it. The stimulus keeps within these limits: each access waits for the controller to be idle, and request fields change only at the falling edge. The bench's memory responder sees each memory request at a falling edge and then raises the matching ready with random delay. The random addresses use a handful of tags per set, so the bench reaches hits, clean evictions and dirty evictions in mixed order.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/cache_way_match.sv
module cache_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  parameter int AGE_W = 1,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0][AGE_W-1:0] ages,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic [WAY_W-1:0]           victim_way
);
  logic any_inv;

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[w] && tags[w] == tag) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  // lowest invalid way first, otherwise the oldest way
  always_comb begin
    any_inv    = 1'b0;
    victim_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[w]) begin
        any_inv    = 1'b1;
        victim_way = WAY_W'(w);
      end
    end
    if (!any_inv) begin
      for (int w = 0; w < WAYS; w++) begin
        if (ages[w] == AGE_W'(WAYS - 1)) victim_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cache_age_update.sv
module cache_age_update #(
  parameter int WAYS  = 2,
  parameter int AGE_W = 1,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0][AGE_W-1:0] ages,
  input  logic [WAY_W-1:0]           way,
  output logic [WAYS-1:0][AGE_W-1:0] new_ages
);
  logic [AGE_W-1:0] old_age;

  always_comb begin
    old_age = ages[way];
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == way)        new_ages[w] = '0;
      else if (ages[w] < old_age)  new_ages[w] = ages[w] + AGE_W'(1);
      else                         new_ages[w] = ages[w];
    end
  end
endmodule

// File: rtl/cache_stats.sv
module cache_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             acc_wr,
  input  logic             acc_hit,
  input  logic             wb_done,
  output logic [CNT_W-1:0] cnt_rd,
  output logic [CNT_W-1:0] cnt_wr,
  output logic [CNT_W-1:0] cnt_rd_hit,
  output logic [CNT_W-1:0] cnt_rd_miss,
  output logic [CNT_W-1:0] cnt_wr_hit,
  output logic [CNT_W-1:0] cnt_wr_miss,
  output logic [CNT_W-1:0] cnt_wb
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_rd      <= '0;
      cnt_wr      <= '0;
      cnt_rd_hit  <= '0;
      cnt_rd_miss <= '0;
      cnt_wr_hit  <= '0;
      cnt_wr_miss <= '0;
      cnt_wb      <= '0;
    end else begin
      if (acc && !acc_wr)             cnt_rd      <= cnt_rd + ONE;
      if (acc && acc_wr)              cnt_wr      <= cnt_wr + ONE;
      if (acc && !acc_wr && acc_hit)  cnt_rd_hit  <= cnt_rd_hit + ONE;
      if (acc && !acc_wr && !acc_hit) cnt_rd_miss <= cnt_rd_miss + ONE;
      if (acc && acc_wr && acc_hit)   cnt_wr_hit  <= cnt_wr_hit + ONE;
      if (acc && acc_wr && !acc_hit)  cnt_wr_miss <= cnt_wr_miss + ONE;
      if (wb_done)                    cnt_wb      <= cnt_wb + ONE;
    end
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl #(
  parameter int ADDR_W = 16,
  parameter int C      = 8,
  parameter int B      = 2,
  parameter int S      = 1,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ready,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_ready,
  output logic [CNT_W-1:0]  cnt_rd,
  output logic [CNT_W-1:0]  cnt_wr,
  output logic [CNT_W-1:0]  cnt_rd_hit,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_wr_hit,
  output logic [CNT_W-1:0]  cnt_wr_miss,
  output logic [CNT_W-1:0]  cnt_wb,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_miss
);
  import cache_pkg::*;

  localparam int WAYS   = 1 << S;
  localparam int IDX_W  = C - B - S;
  localparam int SETS   = 1 << IDX_W;
  localparam int IDXV_W = (IDX_W > 0) ? IDX_W : 1;
  localparam int TAG_W  = ADDR_W - B - IDX_W;
  localparam int WAY_W  = (S > 0) ? S : 1;
  localparam int AGE_W  = WAY_W;
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << B) - 1);

  ctrl_state_e state_q;

  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0]            drt_q [SETS];
  logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];

  logic [IDXV_W-1:0] req_set, m_set, lru_set;
  logic [TAG_W-1:0]  req_tag, m_tag, m_vtag;
  logic [WAY_W-1:0]  hit_way, victim_way, m_way, lru_way;
  logic [ADDR_W-1:0] m_addr;
  logic              m_write, hit, accept;
  logic [WAYS-1:0][AGE_W-1:0] new_ages;

  generate
    if (IDX_W == 0) begin : g_one_set
      assign req_set = '0;
    end else begin : g_many_sets
      assign req_set = req_addr[B +: IDX_W];
    end
  endgenerate
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

  cache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_match (
    .tags(tag_q[req_set]), .vld(vld_q[req_set]), .ages(age_q[req_set]), .tag(req_tag),
    .hit(hit), .hit_way(hit_way), .victim_way(victim_way)
  );

  assign lru_set = (state_q == ST_IDLE) ? req_set : m_set;
  assign lru_way = (state_q == ST_IDLE) ? hit_way : m_way;

  cache_age_update #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_age (
    .ages(age_q[lru_set]), .way(lru_way), .new_ages(new_ages)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign rsp_valid  = accept;
  assign rsp_hit    = accept && hit;
  assign wb_valid   = (state_q == ST_WB);
  assign fill_valid = (state_q == ST_FILL);
  assign fill_addr  = m_addr & ~OFF_MASK;
  assign wb_addr    = {m_vtag, m_addr[ADDR_W-TAG_W-1:0]} & ~OFF_MASK;

  // tag storage: no reset, written only when a fill completes
  always_ff @(posedge clk) begin
    if (state_q == ST_FILL && fill_ready) tag_q[m_set][m_way] <= m_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      m_set   <= '0;
      m_tag   <= '0;
      m_vtag  <= '0;
      m_way   <= '0;
      m_addr  <= '0;
      m_write <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        drt_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
      end
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept && hit) begin
            age_q[req_set] <= new_ages;
            if (req_write) drt_q[req_set][hit_way] <= 1'b1;
          end else if (accept) begin
            m_set   <= req_set;
            m_tag   <= req_tag;
            m_vtag  <= tag_q[req_set][victim_way];
            m_way   <= victim_way;
            m_addr  <= req_addr;
            m_write <= req_write;
            state_q <= (vld_q[req_set][victim_way] && drt_q[req_set][victim_way])
                       ? ST_WB : ST_FILL;
          end
        end
        ST_WB: begin
          if (wb_ready) state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (fill_ready) begin
            vld_q[m_set][m_way] <= 1'b1;
            drt_q[m_set][m_way] <= m_write;
            age_q[m_set]        <= new_ages;
            state_q             <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  cache_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst), .acc(accept), .acc_wr(req_write), .acc_hit(hit),
    .wb_done(wb_valid && wb_ready),
    .cnt_rd(cnt_rd), .cnt_wr(cnt_wr), .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss),
    .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss), .cnt_wb(cnt_wb)
  );

  assign cnt_hit  = cnt_rd_hit + cnt_wr_hit;
  assign cnt_miss = cnt_rd_miss + cnt_wr_miss;
endmodule

// File: rtl/cache_ctrl_props.sv
module cache_ctrl_props #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              wb_valid,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              wb_ready,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              fill_ready,
  input logic [CNT_W-1:0]  cnt_rd,
  input logic [CNT_W-1:0]  cnt_wr,
  input logic [CNT_W-1:0]  cnt_rd_hit,
  input logic [CNT_W-1:0]  cnt_rd_miss,
  input logic [CNT_W-1:0]  cnt_wr_hit,
  input logic [CNT_W-1:0]  cnt_wr_miss,
  input logic [CNT_W-1:0]  cnt_wb
);
  p_hit_no_mem_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |=> (req_ready && !wb_valid && !fill_valid));

  p_miss_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |=> !req_ready);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!wb_valid && !fill_valid));

  p_wb_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

  p_fill_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_addr)));

  p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_ready) |=> fill_valid);

  p_wb_count_r7: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_ready) |=> (cnt_wb == $past(cnt_wb) + CNT_W'(1)));

  p_rd_split_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_rd == CNT_W'(cnt_rd_hit + cnt_rd_miss));

  p_wr_split_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_wr == CNT_W'(cnt_wr_hit + cnt_wr_miss));
endmodule

bind cache_ctrl cache_ctrl_props #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_props (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_ready(wb_ready),
  .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_ready(fill_ready),
  .cnt_rd(cnt_rd), .cnt_wr(cnt_wr), .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss),
  .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss), .cnt_wb(cnt_wb)
);

// File: tb/test_cache_ctrl.sv
module test_cache_ctrl;
  localparam int AW = 12, PC = 6, PB = 2, PS = 1, CW = 32;
  localparam int WAYS = 1 << PS;
  localparam int IDXB = PC - PB - PS;
  localparam int SETS = 1 << IDXB;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic wb_ready = 1'b0, fill_ready = 1'b0;
  logic req_ready, rsp_valid, rsp_hit, wb_valid, fill_valid;
  logic [AW-1:0] wb_addr, fill_addr;
  logic [CW-1:0] cnt_rd, cnt_wr, cnt_rd_hit, cnt_rd_miss, cnt_wr_hit, cnt_wr_miss;
  logic [CW-1:0] cnt_wb, cnt_hit, cnt_miss;

  cache_ctrl #(.ADDR_W(AW), .C(PC), .B(PB), .S(PS), .CNT_W(CW)) i_cache_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_ready(wb_ready),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_ready(fill_ready),
    .cnt_rd(cnt_rd), .cnt_wr(cnt_wr), .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss),
    .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss), .cnt_wb(cnt_wb),
    .cnt_hit(cnt_hit), .cnt_miss(cnt_miss)
  );

  always #10 clk = ~clk;   // 50 MHz

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 1'b0;

  // reference model state
  int m_tag [SETS][WAYS];
  bit m_v   [SETS][WAYS];
  bit m_d   [SETS][WAYS];
  int m_ts  [SETS][WAYS];
  int now_t = 0;
  int e_rd = 0, e_wr = 0, e_rh = 0, e_rm = 0, e_wh = 0, e_wm = 0, e_wb = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model(input bit wr, input int a, output bit hit, output bit dowb,
                       output int wba, output int fla);
    int st = (a >> PB) & (SETS - 1);
    int tg = a >> (PB + IDXB);
    int way = -1;
    now_t++;
    for (int w = 0; w < WAYS; w++) if (m_v[st][w] && m_tag[st][w] == tg) way = w;
    hit = (way >= 0);
    dowb = 1'b0; wba = 0;
    fla = a & ~((1 << PB) - 1);
    if (wr) begin e_wr++; if (hit) e_wh++; else e_wm++; end
    else    begin e_rd++; if (hit) e_rh++; else e_rm++; end
    if (hit) begin
      m_ts[st][way] = now_t;
      if (wr) m_d[st][way] = 1'b1;
    end else begin
      for (int w = WAYS - 1; w >= 0; w--) if (!m_v[st][w]) way = w;
      if (way < 0) begin
        way = 0;
        for (int w = 1; w < WAYS; w++) if (m_ts[st][w] < m_ts[st][way]) way = w;
      end
      if (m_v[st][way] && m_d[st][way]) begin
        dowb = 1'b1; e_wb++;
        wba = (m_tag[st][way] << (PB + IDXB)) | (st << PB);
      end
      m_tag[st][way] = tg; m_v[st][way] = 1'b1; m_d[st][way] = wr; m_ts[st][way] = now_t;
    end
  endtask

  task automatic check_counts();
    chk(cnt_rd == CW'(e_rd), "R9", "cnt_rd", cnt_rd, e_rd);
    chk(cnt_wr == CW'(e_wr), "R9", "cnt_wr", cnt_wr, e_wr);
    chk(cnt_rd_hit == CW'(e_rh), "R9", "cnt_rd_hit", cnt_rd_hit, e_rh);
    chk(cnt_rd_miss == CW'(e_rm), "R9", "cnt_rd_miss", cnt_rd_miss, e_rm);
    chk(cnt_wr_hit == CW'(e_wh), "R9", "cnt_wr_hit", cnt_wr_hit, e_wh);
    chk(cnt_wr_miss == CW'(e_wm), "R9", "cnt_wr_miss", cnt_wr_miss, e_wm);
    chk(cnt_wb == CW'(e_wb), "R7", "cnt_wb", cnt_wb, e_wb);
    chk(cnt_hit == CW'(e_rh + e_wh), "R10", "cnt_hit", cnt_hit, e_rh + e_wh);
    chk(cnt_miss == CW'(e_rm + e_wm), "R10", "cnt_miss", cnt_miss, e_rm + e_wm);
  endtask

  task automatic access(input bit wr, input int a, input string tagname);
    bit eh, ewb;
    int ewa, efa, seen_wb, seen_fill, guard;
    bit order_bad;
    model(wr, a, eh, ewb, ewa, efa);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a);
    #1;
    chk(req_ready && rsp_valid, "R2", "rsp_valid at accept", rsp_valid, 1);
    chk(rsp_hit == eh, "R2", {"hit/miss ", tagname}, rsp_hit, eh);
    @(posedge clk); #1;
    req_valid = 1'b0;
    seen_wb = 0; seen_fill = 0; guard = 0; order_bad = 1'b0;
    forever begin
      @(negedge clk);
      wb_ready = 1'b0; fill_ready = 1'b0;
      #1;
      if (req_ready || guard > 200) break;
      guard++;
      if (wb_valid) begin
        if (seen_fill > 0) order_bad = 1'b1;
        if ($urandom % 2 == 1) begin
          chk(wb_addr == AW'(ewa), "R7", "wb_addr", wb_addr, ewa);
          wb_ready = 1'b1; seen_wb++;
        end
      end else if (fill_valid) begin
        if ($urandom % 2 == 1) begin
          chk(fill_addr == AW'(efa), "R6", "fill_addr", fill_addr, efa);
          fill_ready = 1'b1; seen_fill++;
        end
      end
    end
    chk(!order_bad, "R8", "write-back after fill", order_bad, 0);
    chk(seen_wb == int'(ewb), "R7", "write-back count", seen_wb, ewb);
    chk(seen_fill == int'(!eh), "R6", "fill count", seen_fill, !eh);
    check_counts();
  endtask

  function automatic int mk(input int tg, input int st, input int off);
    return (tg << (PB + IDXB)) | (st << PB) | off;
  endfunction

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_v[s][w] = 1'b0; m_d[s][w] = 1'b0; m_ts[s][w] = 0; m_tag[s][w] = 0;
      end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R3: reset state
    chk(req_ready == 1'b1, "R3", "req_ready after reset", req_ready, 1);
    chk(!wb_valid && !fill_valid, "R3", "memory idle after reset", wb_valid | fill_valid, 0);
    check_counts();
    access(0, mk(3, 1, 0), "R3 first touch");
    // R1: other byte of the same block hits
    access(0, mk(3, 1, 3), "R1 same block");
    access(0, mk(3, 2, 0), "R1 other set");
    // R5 / R4: fill both ways, then read-hit refresh
    access(0, mk(5, 1, 1), "R5 second way");
    access(0, mk(3, 1, 2), "R4 refresh");
    access(0, mk(7, 1, 0), "R4 evict lru");
    access(0, mk(3, 1, 0), "R4 mru kept");
    access(0, mk(5, 1, 0), "R4 evicted gone");
    // R6 / R7: write allocate, dirty eviction, write-hit refresh
    access(1, mk(9, 4, 1), "R6 write miss");
    access(0, mk(10, 4, 0), "R5 fill other way");
    access(1, mk(9, 4, 2), "R7 write hit");
    access(0, mk(11, 4, 0), "R4 write refresh");
    access(0, mk(12, 4, 0), "R7 dirty evict");
    access(1, mk(11, 4, 0), "R7 mark dirty");
    access(0, mk(13, 4, 0), "R7 evict clean");
    access(0, mk(14, 4, 0), "R7 evict dirty");
    // random mix, few tags per set to force reuse and eviction
    for (int i = 0; i < 3000; i++) begin
      access($urandom % 2, mk($urandom % 5, $urandom % SETS, $urandom % (1 << PB)), "random");
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule